// File: doc/BRIEF.md
# Descriptor-Chained Memory Copy Channel

This block is one channel of a memory-to-memory copy engine. Software places one or more six-word descriptors in memory, writes the byte address of the first one into the channel's pointer register and raises the enable input. The channel then reads the descriptor through its read port. It copies the described number of 32-bit words from a source region to a destination region, then follows the descriptor's link word to the next descriptor. The reserved link value `0xFFFFF800` ends the chain.

While it runs, the channel shows the pointer register, the current source and destination addresses and the bytes still to move. It raises three single-cycle event pulses: one at the halfway point of each package, one at the end of each package, and one at the end of the chain. A pause input stops data movement at a word boundary, and the copy later resumes from the same word. Dropping enable aborts the channel at once.

The controller is a named state machine:
- `S_IDLE`: waiting for enable.
- `S_LINK`: checks the alignment of the pointer and latches it as the fetch base.
- `S_FREQ` / `S_FCAP`: issue and capture each descriptor word.
- `S_LOAD`: loads the progress counters.
- `S_RREQ` / `S_WRITE`: read and write one data word.
- `S_PAUSED`: holds a frozen copy.
- `S_PEND`: a package has finished and the link is examined.
- `S_HALT`: chain done or fault, held until enable drops.

The transitions are as follows:
- From any state, low enable leads to `S_IDLE`.
- `S_IDLE` goes to `S_LINK`.
- `S_LINK` goes to `S_HALT` on a misaligned pointer, and to `S_FREQ` otherwise.
- `S_FREQ` goes to `S_FCAP`.
- `S_FCAP` goes to `S_FREQ` until the sixth word, then to `S_LOAD`.
- `S_LOAD` goes to `S_PEND` for a zero count, and to `S_RREQ` otherwise.
- `S_RREQ` goes to `S_PAUSED` while pause is high, and to `S_WRITE` otherwise.
- `S_PAUSED` goes back to `S_RREQ` when pause clears.
- `S_WRITE` goes to `S_PEND` after the last word, and to `S_RREQ` otherwise.
- `S_PEND` goes to `S_HALT` on the null link, and to `S_LINK` otherwise.

Top module: `dma_chain_chan`

## Requirements
- R1: A descriptor is read as six words at ascending byte addresses starting at the pointer: configuration, source, destination, byte count, parameter, link. The channel then copies count/4 words (the low two bits of the count are ignored) from ascending source addresses to ascending destination addresses, with no word written past the end. Every write is preceded by a read one cycle earlier.
- R2: A link equal to `0xFFFFF800` ends the chain after its package. Any other link is the byte address of the next descriptor, which is fetched and executed next.
- R3: Once a descriptor has been fetched, `dptr_q` reads its link word. A software write to the pointer during a package replaces the address followed when that package ends.
- R4: `evt_half` pulses exactly once per package with a nonzero count, in the same cycle as the write of word ceil(N/2), where N is the package's word count.
- R5: `evt_pkg` pulses once at the end of every package. `evt_chain` pulses only together with `evt_pkg`, and only for the package whose link is null.
- R6: No write occurs in a cycle that follows a cycle with `ch_pause` high. After pause is released, the copy completes with every word written exactly once.
- R7: Each write cycle advances `cur_src_q` and `cur_dst_q` by 4 and lowers `left_q` by 4 at the next edge. While paused, these values read the exact progress.
- R8: A pointer or link with bit 1 or bit 0 set stops the channel with `fault` = 1 and `busy` = 0, and no descriptor is fetched from that address.
- R9: `busy` is 1 from the cycle after enable is sampled until the chain ends or a fault occurs. Dropping enable returns the channel to idle: `busy` is 0 the next cycle and no further writes occur.
- R10: A byte count below 4 completes the package at once: `evt_half` and `evt_pkg` pulse together and no data word is written.
- R11: After reset, `busy`, `fault`, `rd_en`, `wr_en` and `left_q` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_enable | input | 1 | Run level; low aborts |
| ch_pause | input | 1 | Freeze data movement at a word boundary |
| dptr_wr | input | 1 | Software write strobe for the pointer |
| dptr_wdata | input | W | Pointer value to write |
| dptr_q | output | W | Pointer / current link readback |
| cfg_q | output | W | Configuration word of the current descriptor |
| param_q | output | W | Parameter word of the current descriptor |
| cur_src_q | output | W | Next source byte address |
| cur_dst_q | output | W | Next destination byte address |
| left_q | output | W | Bytes still to move |
| busy | output | 1 | Channel active |
| fault | output | 1 | Halted on misaligned pointer |
| evt_half | output | 1 | Half-package pulse |
| evt_pkg | output | 1 | Package-done pulse |
| evt_chain | output | 1 | Chain-done pulse |
| rd_en | output | 1 | Memory read request (data returns next cycle) |
| rd_addr | output | W | Memory read byte address |
| rd_data | input | W | Memory read data |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | W | Memory write byte address |
| wr_data | output | W | Memory write data |

## Verification
Single-package transfers of 1, 2, 3, 5 and 8 words at different offsets separate odd from even halfway rounding and expose off-by-one in the last-word test through a guard word after each destination. A two-descriptor chain separates following a link from stopping on it, and a mid-package pointer rewrite shows that the link is read at package end rather than at fetch. Pause, abort, zero count and misaligned pointer and link tests each show whether the corresponding state is entered and left correctly.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;

    localparam int DESC_WORDS = 6;

    typedef enum logic [2:0] {
        W_CFG   = 3'd0,
        W_SRC   = 3'd1,
        W_DST   = 3'd2,
        W_CNT   = 3'd3,
        W_PARAM = 3'd4,
        W_LINK  = 3'd5
    } desc_word_t;

    typedef enum logic [3:0] {
        S_IDLE,
        S_LINK,
        S_FREQ,
        S_FCAP,
        S_LOAD,
        S_RREQ,
        S_PAUSED,
        S_WRITE,
        S_PEND,
        S_HALT
    } chan_state_t;

endpackage

// File: rtl/dma_desc_regs.sv
module dma_desc_regs
    import dma_chain_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sw_wr,
    input  logic [W-1:0] sw_data,
    input  logic         base_load,
    input  logic         idx_clr,
    input  logic         cap_en,
    input  logic [W-1:0] cap_data,
    output logic [W-1:0] dptr,
    output logic [W-1:0] fetch_addr,
    output logic         last_word,
    output logic [W-1:0] cfg,
    output logic [W-1:0] src,
    output logic [W-1:0] dst,
    output logic [W-1:0] cnt,
    output logic [W-1:0] param
);
    localparam int NBODY = int'(W_LINK);

    logic [2:0]   idx;
    logic [W-1:0] base;
    logic [W-1:0] body [NBODY];

    // Body words (all but the link) are captured by index.
    for (genvar g = 0; g < NBODY; g++) begin : g_body
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                body[g] <= '0;
            else if (cap_en && idx == 3'(g))
                body[g] <= cap_data;
        end
    end

    // The pointer register doubles as the link holder; software has priority.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            dptr <= '0;
        else if (sw_wr)
            dptr <= sw_data;
        else if (cap_en && idx == 3'(W_LINK))
            dptr <= cap_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base <= '0;
            idx  <= '0;
        end else begin
            if (base_load)
                base <= dptr;
            if (idx_clr)
                idx <= '0;
            else if (cap_en)
                idx <= idx + 3'd1;
        end
    end

    assign fetch_addr = base + W'({idx, 2'b00});
    assign last_word  = (idx == 3'(W_LINK));
    assign cfg        = body[W_CFG];
    assign src        = body[W_SRC];
    assign dst        = body[W_DST];
    assign cnt        = body[W_CNT];
    assign param      = body[W_PARAM];

endmodule

// File: rtl/dma_xfer_ctr.sv
module dma_xfer_ctr #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic         force_half,
    input  logic [W-1:0] src_in,
    input  logic [W-1:0] dst_in,
    input  logic [W-1:0] cnt_in,
    output logic [W-1:0] src,
    output logic [W-1:0] dst,
    output logic [W-1:0] left,
    output logic         last,
    output logic         half_sent,
    output logic         half_hit
);
    localparam logic [W-1:0] STEP = W'(4);

    logic [W-1:0] total;
    logic [W:0]   twice_next;

    assign twice_next = {left - STEP, 1'b0};
    assign half_hit   = step && !half_sent && (twice_next <= {1'b0, total});
    assign last       = (left == STEP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src       <= '0;
            dst       <= '0;
            left      <= '0;
            total     <= '0;
            half_sent <= 1'b0;
        end else if (load) begin
            src       <= src_in;
            dst       <= dst_in;
            left      <= cnt_in & ~W'(3);
            total     <= cnt_in & ~W'(3);
            half_sent <= 1'b0;
        end else begin
            if (step) begin
                src  <= src + STEP;
                dst  <= dst + STEP;
                left <= left - STEP;
            end
            if (half_hit || force_half)
                half_sent <= 1'b1;
        end
    end

endmodule

// File: rtl/dma_chain_fsm.sv
module dma_chain_fsm
    import dma_chain_pkg::*;
#(
    parameter int           W         = 32,
    parameter logic [W-1:0] LINK_NULL = W'(32'hFFFF_F800)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic         pause,
    input  logic [W-1:0] dptr,
    input  logic         desc_last,
    input  logic         cnt_zero,
    input  logic         xfer_last,
    input  logic         half_sent,
    output logic         base_load,
    output logic         idx_clr,
    output logic         cap_en,
    output logic         ctr_load,
    output logic         step,
    output logic         rd_en,
    output logic         rd_fetch,
    output logic         wr_en,
    output logic         busy,
    output logic         fault,
    output logic         evt_pkg,
    output logic         evt_chain,
    output logic         pend_half
);
    chan_state_t state, nxt;
    logic        fault_q;
    logic        misaligned;
    logic        is_null;

    assign misaligned = (dptr[1:0] != 2'b00);
    assign is_null    = (dptr == LINK_NULL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            fault_q <= 1'b0;
        end else begin
            state <= nxt;
            if (nxt == S_IDLE)
                fault_q <= 1'b0;
            else if (state == S_LINK && misaligned)
                fault_q <= 1'b1;
        end
    end

    always_comb begin
        nxt = state;
        if (!enable) begin
            nxt = S_IDLE;
        end else begin
            unique case (state)
                S_IDLE:   nxt = S_LINK;
                S_LINK:   nxt = misaligned ? S_HALT : S_FREQ;
                S_FREQ:   nxt = S_FCAP;
                S_FCAP:   nxt = desc_last ? S_LOAD : S_FREQ;
                S_LOAD:   nxt = cnt_zero ? S_PEND : S_RREQ;
                S_RREQ:   nxt = pause ? S_PAUSED : S_WRITE;
                S_PAUSED: nxt = pause ? S_PAUSED : S_RREQ;
                S_WRITE:  nxt = xfer_last ? S_PEND : S_RREQ;
                S_PEND:   nxt = is_null ? S_HALT : S_LINK;
                S_HALT:   nxt = S_HALT;
                default:  nxt = S_IDLE;
            endcase
        end
    end

    always_comb begin
        base_load = 1'b0;
        idx_clr   = 1'b0;
        cap_en    = 1'b0;
        ctr_load  = 1'b0;
        step      = 1'b0;
        rd_en     = 1'b0;
        rd_fetch  = 1'b0;
        wr_en     = 1'b0;
        evt_pkg   = 1'b0;
        evt_chain = 1'b0;
        pend_half = 1'b0;
        busy      = 1'b1;
        fault     = 1'b0;
        unique case (state)
            S_IDLE: busy = 1'b0;
            S_LINK: begin
                base_load = 1'b1;
                idx_clr   = 1'b1;
            end
            S_FREQ: begin
                rd_en    = 1'b1;
                rd_fetch = 1'b1;
            end
            S_FCAP:   cap_en = 1'b1;
            S_LOAD:   ctr_load = 1'b1;
            S_RREQ:   rd_en = !pause;
            S_PAUSED: ;
            S_WRITE: begin
                wr_en = 1'b1;
                step  = 1'b1;
            end
            S_PEND: begin
                evt_pkg   = 1'b1;
                evt_chain = is_null;
                pend_half = !half_sent;
            end
            S_HALT: begin
                busy  = 1'b0;
                fault = fault_q;
            end
            default: busy = 1'b0;
        endcase
    end

endmodule

// File: rtl/dma_chain_chan.sv
module dma_chain_chan
    import dma_chain_pkg::*;
#(
    parameter int           W         = 32,
    parameter logic [W-1:0] LINK_NULL = W'(32'hFFFF_F800)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ch_enable,
    input  logic         ch_pause,
    input  logic         dptr_wr,
    input  logic [W-1:0] dptr_wdata,
    output logic [W-1:0] dptr_q,
    output logic [W-1:0] cfg_q,
    output logic [W-1:0] param_q,
    output logic [W-1:0] cur_src_q,
    output logic [W-1:0] cur_dst_q,
    output logic [W-1:0] left_q,
    output logic         busy,
    output logic         fault,
    output logic         evt_half,
    output logic         evt_pkg,
    output logic         evt_chain,
    output logic         rd_en,
    output logic [W-1:0] rd_addr,
    input  logic [W-1:0] rd_data,
    output logic         wr_en,
    output logic [W-1:0] wr_addr,
    output logic [W-1:0] wr_data
);
    logic         base_load, idx_clr, cap_en, ctr_load, step, rd_fetch;
    logic         desc_last, xfer_last, half_sent, half_hit, pend_half;
    logic [W-1:0] fetch_addr, d_src, d_dst, d_cnt;

    dma_desc_regs #(.W(W)) u_desc (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_wr      (dptr_wr),
        .sw_data    (dptr_wdata),
        .base_load  (base_load),
        .idx_clr    (idx_clr),
        .cap_en     (cap_en),
        .cap_data   (rd_data),
        .dptr       (dptr_q),
        .fetch_addr (fetch_addr),
        .last_word  (desc_last),
        .cfg        (cfg_q),
        .src        (d_src),
        .dst        (d_dst),
        .cnt        (d_cnt),
        .param      (param_q)
    );

    dma_xfer_ctr #(.W(W)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (ctr_load),
        .step       (step),
        .force_half (pend_half),
        .src_in     (d_src),
        .dst_in     (d_dst),
        .cnt_in     (d_cnt),
        .src        (cur_src_q),
        .dst        (cur_dst_q),
        .left       (left_q),
        .last       (xfer_last),
        .half_sent  (half_sent),
        .half_hit   (half_hit)
    );

    dma_chain_fsm #(.W(W), .LINK_NULL(LINK_NULL)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (ch_enable),
        .pause      (ch_pause),
        .dptr       (dptr_q),
        .desc_last  (desc_last),
        .cnt_zero   (d_cnt[W-1:2] == '0),
        .xfer_last  (xfer_last),
        .half_sent  (half_sent),
        .base_load  (base_load),
        .idx_clr    (idx_clr),
        .cap_en     (cap_en),
        .ctr_load   (ctr_load),
        .step       (step),
        .rd_en      (rd_en),
        .rd_fetch   (rd_fetch),
        .wr_en      (wr_en),
        .busy       (busy),
        .fault      (fault),
        .evt_pkg    (evt_pkg),
        .evt_chain  (evt_chain),
        .pend_half  (pend_half)
    );

    assign rd_addr  = rd_fetch ? fetch_addr : cur_src_q;
    assign wr_addr  = cur_dst_q;
    assign wr_data  = rd_data;
    assign evt_half = half_hit || pend_half;

endmodule

// File: rtl/dma_chain_chk.sv
module dma_chain_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         ch_enable,
    input logic         ch_pause,
    input logic         busy,
    input logic         fault,
    input logic         evt_pkg,
    input logic         evt_chain,
    input logic         rd_en,
    input logic         wr_en,
    input logic [W-1:0] left_q,
    input logic [W-1:0] cur_src_q,
    input logic [W-1:0] cur_dst_q
);
    // R8
    fault_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> !busy);

    // R5
    chain_with_pkg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_chain |-> evt_pkg);

    // R6
    pause_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ch_pause) |-> !wr_en);

    // R7
    left_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> left_q == $past(left_q) - W'(4));

    // R7
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (cur_src_q == $past(cur_src_q) + W'(4)) && (cur_dst_q == $past(cur_dst_q) + W'(4)));

    // R9
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ch_enable |=> !busy);

    // R1
    read_before_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(rd_en));

endmodule

bind dma_chain_chan dma_chain_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ch_enable (ch_enable),
    .ch_pause  (ch_pause),
    .busy      (busy),
    .fault     (fault),
    .evt_pkg   (evt_pkg),
    .evt_chain (evt_chain),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .left_q    (left_q),
    .cur_src_q (cur_src_q),
    .cur_dst_q (cur_dst_q)
);

// File: tb/sim_dma_chain_chan.sv
`timescale 1ns/1ps
module sim_dma_chain_chan;
    localparam logic [31:0] NUL = 32'hFFFF_F800;
    localparam int NV = 5;
    localparam int V_SRC  [NV] = '{64, 64, 70, 80, 66};
    localparam int V_DST  [NV] = '{160, 160, 170, 200, 190};
    localparam int V_N    [NV] = '{1, 2, 5, 8, 3};
    localparam int V_HALF [NV] = '{1, 1, 3, 4, 2};

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        ch_enable = 1'b0, ch_pause = 1'b0, dptr_wr = 1'b0;
    logic [31:0] dptr_wdata = '0, rd_data = '0;
    logic [31:0] dptr_q, cfg_q, param_q, cur_src_q, cur_dst_q, left_q;
    logic [31:0] rd_addr, wr_addr, wr_data;
    logic        busy, fault, evt_half, evt_pkg, evt_chain, rd_en, wr_en;
    logic [31:0] mem [0:255];

    int n_chk = 0, n_fail = 0;
    int n_wr = 0, n_half = 0, n_pkg = 0, n_chain = 0, half_at = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    dma_chain_chan u0 (.*);

    always @(posedge clk) begin
        if (rd_en) rd_data <= mem[rd_addr[9:2]];
        if (wr_en) mem[wr_addr[9:2]] <= wr_data;
    end

    always @(negedge clk) if (rst_n) begin
        if (wr_en) n_wr++;
        if (evt_half) begin n_half++; half_at = n_wr; end
        if (evt_pkg) n_pkg++;
        if (evt_chain) n_chain++;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic put_desc(input int w, input int sw, input int dw, input int nbytes, input logic [31:0] link);
        mem[w]   = 32'h0000_0001;
        mem[w+1] = sw * 4;
        mem[w+2] = dw * 4;
        mem[w+3] = nbytes;
        mem[w+4] = 32'h0000_00AA;
        mem[w+5] = link;
    endtask

    task automatic prep(input int sw, input int dw, input int n, input int tag);
        for (int i = 0; i < n; i++) mem[sw+i] = 32'hC0DE_0000 + tag * 256 + i;
        for (int i = 0; i <= n; i++) mem[dw+i] = 32'h0;
    endtask

    function automatic int bad_words(input int sw, input int dw, input int n, input int tag);
        int b = 0;
        for (int i = 0; i < n; i++) if (mem[dw+i] !== 32'hC0DE_0000 + tag * 256 + i) b++;
        if (mem[dw+n] !== 32'h0) b++;
        return b + (sw - sw);
    endfunction

    task automatic sw_ptr(input logic [31:0] a);
        dptr_wr = 1'b1; dptr_wdata = a;
        tick();
        dptr_wr = 1'b0;
    endtask

    task automatic start(input logic [31:0] a);
        n_wr = 0; n_half = 0; n_pkg = 0; n_chain = 0; half_at = 0;
        sw_ptr(a);
        ch_enable = 1'b1;
        tick(2);
    endtask

    task automatic wait_end();
        int c = 0;
        while (busy && c < 2000) begin tick(); c++; end
        tick();
    endtask

    task automatic stop_chan();
        ch_enable = 1'b0;
        tick(2);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        tick(3);
        rst_n = 1'b1;
        tick(2);
        // R11 reset state
        chk("R11 busy", busy, 0);
        chk("R11 fault", fault, 0);
        chk("R11 rd_en/wr_en", {rd_en, wr_en}, 0);
        chk("R11 left_q", left_q, 0);

        // Vector table: single-package transfers
        for (int v = 0; v < NV; v++) begin
            prep(V_SRC[v], V_DST[v], V_N[v], v);
            put_desc(0, V_SRC[v], V_DST[v], V_N[v] * 4, NUL);
            start(32'h0);
            chk("R9 busy while running", busy, 1);
            wait_end();
            chk("R1 copied words", bad_words(V_SRC[v], V_DST[v], V_N[v], v), 0);
            chk("R1 write count", n_wr, V_N[v]);
            chk("R4 half count", n_half, 1);
            chk("R4 half position", half_at, V_HALF[v]);
            chk("R5 pkg count", n_pkg, 1);
            chk("R2 R5 chain count", n_chain, 1);
            chk("R9 idle after chain", busy, 0);
            stop_chan();
        end

        // R2 two-descriptor chain
        prep(64, 160, 4, 10);
        prep(70, 180, 3, 11);
        put_desc(0, 64, 160, 16, 32'd32);
        put_desc(8, 70, 180, 12, NUL);
        start(32'h0);
        wait_end();
        chk("R2 first package data", bad_words(64, 160, 4, 10), 0);
        chk("R2 second package data", bad_words(70, 180, 3, 11), 0);
        chk("R2 pkg count", n_pkg, 2);
        chk("R2 chain count", n_chain, 1);
        chk("R4 half per package", n_half, 2);
        stop_chan();

        // R3 readback and mid-package redirection
        prep(64, 160, 16, 12);
        prep(96, 200, 4, 13);
        put_desc(0, 64, 160, 64, NUL);
        put_desc(8, 96, 200, 16, NUL);
        start(32'h0);
        while (n_wr < 2) tick();
        chk("R3 link readback", dptr_q, NUL);
        chk("R1 cfg readback", cfg_q, 32'h1);
        chk("R1 param readback", param_q, 32'hAA);
        sw_ptr(32'd32);
        wait_end();
        chk("R3 redirected data", bad_words(96, 200, 4, 13), 0);
        chk("R3 original data", bad_words(64, 160, 16, 12), 0);
        chk("R3 pkg count", n_pkg, 2);
        chk("R3 chain count", n_chain, 1);
        stop_chan();

        // R6 R7 pause and resume
        begin
            int w0;
            prep(64, 160, 8, 14);
            put_desc(0, 64, 160, 32, NUL);
            start(32'h0);
            while (n_wr < 3) tick();
            ch_pause = 1'b1;
            tick(3);
            w0 = n_wr;
            tick(20);
            chk("R6 no writes while paused", n_wr, w0);
            chk("R7 left while paused", left_q, (8 - w0) * 4);
            chk("R7 src while paused", cur_src_q, 64 * 4 + w0 * 4);
            chk("R7 dst while paused", cur_dst_q, 160 * 4 + w0 * 4);
            chk("R9 busy while paused", busy, 1);
            ch_pause = 1'b0;
            wait_end();
            chk("R6 data after resume", bad_words(64, 160, 8, 14), 0);
            chk("R6 write count after resume", n_wr, 8);
            stop_chan();
        end

        // R10 zero and sub-word count
        put_desc(0, 64, 160, 0, NUL);
        start(32'h0);
        wait_end();
        chk("R10 no writes", n_wr, 0);
        chk("R10 half", n_half, 1);
        chk("R10 pkg", n_pkg, 1);
        chk("R10 chain", n_chain, 1);
        stop_chan();
        put_desc(0, 64, 160, 3, NUL);
        start(32'h0);
        wait_end();
        chk("R10 count 3 no writes", n_wr, 0);
        chk("R10 count 3 pkg", n_pkg, 1);
        stop_chan();

        // R8 misaligned start and link
        start(32'h0000_0102);
        wait_end();
        chk("R8 fault on start", fault, 1);
        chk("R8 busy low", busy, 0);
        chk("R8 nothing done", n_pkg + n_wr, 0);
        stop_chan();
        chk("R8 fault clears on idle", fault, 0);
        prep(64, 160, 2, 15);
        put_desc(0, 64, 160, 8, 32'h0000_0106);
        start(32'h0);
        wait_end();
        chk("R8 package before bad link", n_pkg, 1);
        chk("R8 fault on link", fault, 1);
        chk("R8 no chain event", n_chain, 0);
        stop_chan();

        // R9 abort
        begin
            int w1;
            prep(64, 160, 16, 16);
            put_desc(0, 64, 160, 64, NUL);
            start(32'h0);
            while (n_wr < 3) tick();
            ch_enable = 1'b0;
            tick();
            chk("R9 busy low after abort", busy, 0);
            w1 = n_wr;
            tick(10);
            chk("R9 no writes after abort", n_wr, w1);
            chk("R9 no pkg after abort", n_pkg, 0);
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule